// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Unit

This block is the rotate, shift and single-bit datapath of an 8-bit processor core. Each cycle it takes an operation code, a bit index, an operand byte and the current flag byte. It computes the new operand byte and the new flag byte in one combinational pass. The results are held in an output register, so they appear at the outputs one clock after the inputs are presented. Operand fetch and addressing belong to the surrounding core.

The unit covers four groups of operations. The first group holds the long rotates, which are circular or through the carry, in both directions. The second group holds the long shifts: arithmetic left, arithmetic right, logical right, and a left shift that fills bit 0 with a one. The third group is the short accumulator rotates, which touch only the carry, half-carry and subtract flags. The fourth group is the single-bit operations: test, set and clear.

The flag byte uses this layout: sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 are not computed here.

Top module: `rsb_unit`

## Requirements
- R1: With `rst_n` low at a clock edge, `result_q` and `flags_out` become zero at that edge. Otherwise both outputs load the values computed from the inputs sampled at that edge.
- R2: Code 0 rotates circularly left: bit 7 moves to bit 0 and to carry. Code 1 rotates circularly right: bit 0 moves to bit 7 and to carry. For both, sign equals result bit 7, zero is set when the result is 0, parity is set when the result has an even number of ones, and half-carry and subtract are cleared.
- R3: Code 2 rotates left through carry: the old carry enters bit 0 and bit 7 leaves into carry. Code 3 rotates right through carry: the old carry enters bit 7 and bit 0 leaves into carry. Sign, zero, parity, half-carry and subtract follow the rules of R2.
- R4: Code 4 shifts left and fills bit 0 with a zero. Code 5 shifts right and keeps bit 7. Code 7 shifts right and fills bit 7 with a zero. The bit shifted out goes to carry, and the other flags follow the rules of R2.
- R5: Code 6 shifts left and fills bit 0 with a one. Bit 7 goes to carry, and the other flags follow the rules of R2. For example, 0x55 gives 0xAB with flags 0x80.
- R6: Codes 8, 9, 10 and 11 compute the same result and carry as codes 0, 1, 2 and 3 respectively. They clear half-carry and subtract, and leave sign, zero and parity as they came in.
- R7: Code 12 tests operand bit `bit_sel`. Zero is set when that bit is 0, half-carry is set, subtract is cleared, and sign, parity and carry are kept. The result equals the operand.
- R8: Code 13 sets operand bit `bit_sel` and code 14 clears it. No other bit changes, and the flag byte passes through unchanged.
- R9: Flag bits 5 and 3 always pass through from `flags_in`. Code 15 returns the operand and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code (see requirements) |
| bit_sel | input | 3 | Bit index for test, set and clear |
| operand | input | 8 | Operand byte |
| flags_in | input | 8 | Incoming flag byte |
| result_q | output | 8 | Registered result byte |
| flags_out | output | 8 | Registered flag byte |

## Verification
The bench builds the unit with its default 8-bit data width, so the bit index is 3 bits wide. This default lets random stimulus reach every bit position for test, set and clear. It also lets random stimulus reach all sixteen operation codes, including the unused one. Directed cases cover the boundary patterns: 0x80 and 0x01 through each rotate, both carry-in values, a sign-preserving shift of 0xAA, and the one-fill shift of 0x55. The random flag bytes also exercise the flags that the short rotates and the bit operations must keep.

// File: rtl/rsb_pkg.sv
// Package: operation codes, flag bit positions and the operation
// classifier shared by the unit, its submodules and its checker.
package rsb_pkg;

    // Flag byte layout; the surrounding core decodes these positions.
    localparam int FLAG_W = 8;
    localparam int F_S = 7;
    localparam int F_Z = 6;
    localparam int F_H = 4;
    localparam int F_P = 2;
    localparam int F_N = 1;
    localparam int F_C = 0;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SLS  = 4'd6,
        OP_SRL  = 4'd7,
        OP_RLCA = 4'd8,
        OP_RRCA = 4'd9,
        OP_RLA  = 4'd10,
        OP_RRA  = 4'd11,
        OP_BTST = 4'd12,
        OP_BSET = 4'd13,
        OP_BCLR = 4'd14,
        OP_NOP  = 4'd15
    } rsb_op_e;

    // Flag update class of each operation.
    typedef enum logic [1:0] {
        CL_LONG  = 2'd0,
        CL_SHORT = 2'd1,
        CL_TEST  = 2'd2,
        CL_KEEP  = 2'd3
    } rsb_class_e;

    // Map an operation code onto its flag update class.
    function automatic rsb_class_e op_class(input logic [OP_W-1:0] op);
        if (op <= OP_SRL)       return CL_LONG;
        else if (op <= OP_RRA)  return CL_SHORT;
        else if (op == OP_BTST) return CL_TEST;
        else                    return CL_KEEP;
    endfunction

    // True when the operation takes its result from the bit path.
    function automatic logic uses_bit_path(input logic [OP_W-1:0] op);
        return (op >= OP_BTST);
    endfunction

endpackage

// File: rtl/rsb_shift_core.sv
// Rotate and shift datapath.
// Does: computes the rotated or shifted byte and the bit that leaves it.
// Assumes: DATA_W >= 2; codes outside the rotate/shift set pass the
// operand through and return the incoming carry.
module rsb_shift_core
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] din,
    input  logic              carry_in,
    output logic [DATA_W-1:0] dout,
    output logic              carry_out
);
    localparam int MSB = DATA_W - 1;

    // Select the shifted byte and the outgoing bit per operation.
    always_comb begin
        dout      = din;
        carry_out = carry_in;
        case (op)
            OP_RLC, OP_RLCA: begin
                dout      = {din[MSB-1:0], din[MSB]};
                carry_out = din[MSB];
            end
            OP_RRC, OP_RRCA: begin
                dout      = {din[0], din[MSB:1]};
                carry_out = din[0];
            end
            OP_RL, OP_RLA: begin
                dout      = {din[MSB-1:0], carry_in};
                carry_out = din[MSB];
            end
            OP_RR, OP_RRA: begin
                dout      = {carry_in, din[MSB:1]};
                carry_out = din[0];
            end
            OP_SLA: begin
                dout      = {din[MSB-1:0], 1'b0};
                carry_out = din[MSB];
            end
            OP_SLS: begin
                dout      = {din[MSB-1:0], 1'b1};
                carry_out = din[MSB];
            end
            OP_SRA: begin
                dout      = {din[MSB], din[MSB:1]};
                carry_out = din[0];
            end
            OP_SRL: begin
                dout      = {1'b0, din[MSB:1]};
                carry_out = din[0];
            end
            default: begin
                dout      = din;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/rsb_bit_core.sv
// Single-bit datapath.
// Does: decodes the bit index into a one-hot mask, sets or clears the
// selected bit, and reports the selected bit's value for the test.
// Assumes: bit_sel is always below DATA_W.
module rsb_bit_core
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              sel_bit
);
    logic [DATA_W-1:0] mask;

    // One decoder comparator per bit position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (bit_sel == IDX_W'(g));
    end

    // Apply the mask according to the operation.
    always_comb begin
        case (op)
            OP_BSET: dout = din | mask;
            OP_BCLR: dout = din & ~mask;
            default: dout = din;
        endcase
    end

    // Value of the selected bit, used by the test operation.
    assign sel_bit = |(din & mask);
endmodule

// File: rtl/rsb_flag_gen.sv
// Flag generator.
// Does: builds the new flag byte from the result, the outgoing carry,
// the tested bit and the incoming flags, per operation class.
// Assumes: the flag layout of rsb_pkg; bits not named there pass through.
module rsb_flag_gen
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] res,
    input  logic              carry_out,
    input  logic              sel_bit,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags
);
    rsb_class_e cls;
    assign cls = op_class(op);

    // Merge the computed flags over the incoming flag byte.
    always_comb begin
        flags = flags_in;
        case (cls)
            CL_LONG: begin
                flags[F_S] = res[DATA_W-1];
                flags[F_Z] = ~|res;
                flags[F_H] = 1'b0;
                flags[F_P] = ~^res;
                flags[F_N] = 1'b0;
                flags[F_C] = carry_out;
            end
            CL_SHORT: begin
                flags[F_H] = 1'b0;
                flags[F_N] = 1'b0;
                flags[F_C] = carry_out;
            end
            CL_TEST: begin
                flags[F_Z] = ~sel_bit;
                flags[F_H] = 1'b1;
                flags[F_N] = 1'b0;
            end
            default: flags = flags_in;
        endcase
    end
endmodule

// File: rtl/rsb_unit.sv
// Rotate, shift and single-bit unit (top).
// Does: runs the shift path and the bit path in parallel, selects one,
// generates flags, and registers result and flags for one-cycle latency.
// Assumes: synchronous active-low reset clears both output registers.
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result_q,
    output logic [7:0]        flags_out
);
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] res_d;
    logic              carry_out;
    logic              sel_bit;
    logic [FLAG_W-1:0] flags_d;

    rsb_shift_core #(.DATA_W(DATA_W)) u_shift (
        .op        (op_sel),
        .din       (operand),
        .carry_in  (flags_in[F_C]),
        .dout      (shift_res),
        .carry_out (carry_out)
    );

    rsb_bit_core #(.DATA_W(DATA_W)) u_bit (
        .op      (op_sel),
        .bit_sel (bit_sel),
        .din     (operand),
        .dout    (bit_res),
        .sel_bit (sel_bit)
    );

    // Pick the datapath that owns this operation.
    assign res_d = uses_bit_path(op_sel) ? bit_res : shift_res;

    rsb_flag_gen #(.DATA_W(DATA_W)) u_flag (
        .op        (op_sel),
        .res       (res_d),
        .carry_out (carry_out),
        .sel_bit   (sel_bit),
        .flags_in  (flags_in),
        .flags     (flags_d)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            flags_out <= '0;
        end else begin
            result_q  <= res_d;
            flags_out <= flags_d;
        end
    end
endmodule

// File: rtl/rsb_unit_chk.sv
// Checker for rsb_unit: port-level properties over one cycle of latency.
// Assumes: outputs reflect the inputs of the previous edge once the
// previous edge was out of reset (tracked by primed).
module rsb_unit_chk
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [IDX_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] operand,
    input logic [7:0]        flags_in,
    input logic [DATA_W-1:0] result_q,
    input logic [7:0]        flags_out
);
    logic primed;

    // Marks that the previous edge loaded real results.
    always_ff @(posedge clk) begin
        primed <= rst_n;
    end

    // R8: set and clear leave the flag byte unchanged.
    p_bitop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ($past(op_sel) == OP_BSET || $past(op_sel) == OP_BCLR))
        |-> flags_out == $past(flags_in));

    // R8: set changes at most one bit and the selected bit ends high.
    p_bitset_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == OP_BSET)
        |-> result_q[$past(bit_sel)] && $countones(result_q ^ $past(operand)) <= 1);

    // R7: test keeps the operand and carry, sets H, clears N.
    p_test_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == OP_BTST)
        |-> result_q == $past(operand) && flags_out[F_C] == $past(flags_in[F_C])
            && flags_out[F_H] && !flags_out[F_N]);

    // R6: short rotates keep sign, zero and parity.
    p_short_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) >= OP_RLCA && $past(op_sel) <= OP_RRA)
        |-> flags_out[F_S] == $past(flags_in[F_S]) && flags_out[F_Z] == $past(flags_in[F_Z])
            && flags_out[F_P] == $past(flags_in[F_P]) && !flags_out[F_H] && !flags_out[F_N]);

    // R2: long forms report zero exactly when the result is zero.
    p_long_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) <= OP_SRL)
        |-> flags_out[F_Z] == (result_q == '0) && !flags_out[F_H] && !flags_out[F_N]);

    // R9: flag bits 5 and 3 pass through.
    p_spare_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3]));

    // R1: reset clears both outputs at the next edge.
    p_reset_r1: assert property (@(posedge clk)
        $fell(rst_n) |=> result_q == '0 && flags_out == '0);
endmodule

bind rsb_unit rsb_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .bit_sel   (bit_sel),
    .operand   (operand),
    .flags_in  (flags_in),
    .result_q  (result_q),
    .flags_out (flags_out)
);

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] operand = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] result_q;
    logic [7:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .bit_sel   (bit_sel),
        .operand   (operand),
        .flags_in  (flags_in),
        .result_q  (result_q),
        .flags_out (flags_out)
    );

    function automatic logic par_even(input logic [7:0] v);
        return ($countones(v) % 2) == 0;
    endfunction

    // Reference model from the requirements: returns {result, flags}.
    function automatic logic [15:0] model(input logic [3:0] op, input logic [2:0] idx,
                                          input logic [7:0] d, input logic [7:0] f);
        logic [7:0] r;
        logic [7:0] nf;
        logic c;
        r = d; nf = f; c = f[0];
        case (op)
            4'd0, 4'd8:  begin r = {d[6:0], d[7]}; c = d[7]; end
            4'd1, 4'd9:  begin r = {d[0], d[7:1]}; c = d[0]; end
            4'd2, 4'd10: begin r = {d[6:0], f[0]}; c = d[7]; end
            4'd3, 4'd11: begin r = {f[0], d[7:1]}; c = d[0]; end
            4'd4:        begin r = d << 1; c = d[7]; end
            4'd5:        begin r = {d[7], d[7:1]}; c = d[0]; end
            4'd6:        begin r = (d << 1) | 8'h01; c = d[7]; end
            4'd7:        begin r = d >> 1; c = d[0]; end
            4'd13:       r = d | (8'h01 << idx);
            4'd14:       r = d & ~(8'h01 << idx);
            default:     r = d;
        endcase
        if (op <= 4'd7) begin
            nf[7] = r[7]; nf[6] = (r == 8'h00); nf[4] = 1'b0;
            nf[2] = par_even(r); nf[1] = 1'b0; nf[0] = c;
        end else if (op <= 4'd11) begin
            nf[4] = 1'b0; nf[1] = 1'b0; nf[0] = c;
        end else if (op == 4'd12) begin
            nf[6] = ~d[idx]; nf[4] = 1'b1; nf[1] = 1'b0;
        end
        return {r, nf};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd1) return "R2";
        if (op <= 4'd3) return "R3";
        if (op == 4'd6) return "R5";
        if (op <= 4'd7) return "R4";
        if (op <= 4'd11) return "R6";
        if (op == 4'd12) return "R7";
        if (op <= 4'd14) return "R8";
        return "R9";
    endfunction

    // Drive at a falling edge; the registered result is checked one
    // rising edge later, at the following falling edge.
    task automatic apply(input logic [3:0] op, input logic [2:0] idx,
                         input logic [7:0] d, input logic [7:0] f, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        op_sel = op; bit_sel = idx; operand = d; flags_in = f;
        exp = model(op, idx, d, f);
        @(negedge clk);
        checks++;
        if ({result_q, flags_out} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d idx=%0d d=%h f=%h: actual %h/%h expected %h/%h",
                     tag, op, idx, d, f, result_q, flags_out, exp[15:8], exp[7:0]);
        end
    endtask

    task automatic expect_val(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        op_sel = 4'd6; operand = 8'hFF; flags_in = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_val({result_q, flags_out}, 16'h0000, "R1 reset");
        rst_n = 1'b1;

        // Directed corner cases with hand-worked expectations.
        apply(4'd2, 3'd0, 8'h80, 8'h00, "R3 rl 0x80");
        expect_val({result_q, flags_out}, 16'h0045, "R3 rl 0x80 literal");
        apply(4'd3, 3'd0, 8'h01, 8'h00, "R3 rr 0x01");
        expect_val({result_q, flags_out}, 16'h0045, "R3 rr 0x01 literal");
        apply(4'd2, 3'd0, 8'h00, 8'h01, "R3 rl carry in");
        apply(4'd0, 3'd0, 8'h80, 8'h00, "R2 rlc 0x80");
        expect_val({result_q, flags_out[0]}, 9'h003, "R2 rlc literal");
        apply(4'd1, 3'd0, 8'h01, 8'h00, "R2 rrc 0x01");
        expect_val({result_q, flags_out}, 16'h8081, "R2 rrc literal");
        apply(4'd10, 3'd0, 8'h80, 8'h00, "R6 rla 0x80");
        expect_val({result_q, flags_out}, 16'h0001, "R6 rla literal");
        apply(4'd8, 3'd0, 8'h80, 8'hD6, "R6 rlca keep");
        apply(4'd4, 3'd0, 8'h55, 8'h00, "R4 sla 0x55");
        expect_val({result_q, flags_out}, 16'hAA84, "R4 sla literal");
        apply(4'd6, 3'd0, 8'h55, 8'h00, "R5 sls 0x55");
        expect_val({result_q, flags_out}, 16'hAB80, "R5 sls literal");
        apply(4'd5, 3'd0, 8'hAA, 8'h00, "R4 sra 0xAA");
        expect_val({result_q, flags_out}, 16'hD580, "R4 sra literal");
        apply(4'd7, 3'd0, 8'hAA, 8'h00, "R4 srl 0xAA");
        expect_val({result_q, flags_out}, 16'h5504, "R4 srl literal");
        apply(4'd12, 3'd3, 8'h0F, 8'h43, "R7 test set bit");
        expect_val({result_q, flags_out}, 16'h0F11, "R7 test literal");
        apply(4'd12, 3'd7, 8'h0F, 8'h81, "R7 test clear bit");
        apply(4'd14, 3'd0, 8'hFF, 8'hA5, "R8 clear bit 0");
        expect_val({result_q, flags_out}, 16'hFEA5, "R8 clear literal");
        apply(4'd13, 3'd7, 8'h00, 8'h5A, "R8 set bit 7");
        apply(4'd15, 3'd2, 8'h3C, 8'h28, "R9 unused code");
        expect_val({result_q, flags_out}, 16'h3C28, "R9 unused literal");
        apply(4'd4, 3'd0, 8'h80, 8'h28, "R9 spare bits kept");

        // Constrained random: every code, index and flag byte.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            apply(op, 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), tag_of(op));
        end

        // R1: reset again mid-stream clears the outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_val({result_q, flags_out}, 16'h0000, "R1 reset mid-run");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule